// File: doc/BRIEF.md
# Single-Wire Carrier Keying Controller

This block is the sequencer that sits behind one shared open-drain line between a host and a low-frequency carrier transmitter. The host keys the carrier by pulling the line low. The controller drives the same line low once, at the end of a frame, to report the outcome. While idle the controller rests in standby. A high-to-low transition on the line wakes it. Low and high levels must each hold for a debounce window before the carrier follows them. A watchdog ends a transmission whose line stays low too long, and any high period on the line restarts that watchdog. Once the line has been idle high long enough, the controller pulls the line low for a long pulse (success) or a shorter pulse (a fault was reported during the frame), and then returns to standby.

The block takes three inputs: a line sample that is already synchronised, a timing-enable tick, and a fault indication. Every duration is a count of ticks, so one system clock can be scaled to the carrier rate. The block's own pull-down comes back through the synchroniser as a low level. It is kept out of the wake-up, debounce and watchdog logic: the line is ignored while the block drives it, and after standby is entered a wake-up needs the line to be seen high first.

Top module: `lfw_line_ctrl`

## Requirements
- R1: While reset is applied and after reset is released with the line high, `standby` is 1 and both `carrier_en` and `line_pull` are 0.
- R2: In standby, once the line has been seen high, a low sample clears `standby` on the next clock edge.
- R3: `carrier_en` rises only after the line has been low for DEB_LO_TICKS consecutive ticks while active. A shorter low leaves the carrier off.
- R4: With the carrier on, `carrier_en` falls after DEB_HI_TICKS consecutive high ticks. A shorter high period leaves it on.
- R5: If the line stays low for STUCK_TICKS consecutive ticks while active, `carrier_en` goes to 0 and `standby` to 1. The controller then stays in standby for as long as the line stays low.
- R6: Any high sample restarts the low-level watchdog. Short high pulses repeated within STUCK_TICKS therefore keep the carrier on indefinitely.
- R7: After DEB_HI_TICKS... more precisely, after IDLE_TICKS consecutive high ticks while active with no fault recorded, `line_pull` is 1 for exactly ACK_TICKS ticks.
- R8: If `fault_in` was 1 in any cycle while active, the end-of-frame pulse lasts exactly ERR_TICKS ticks instead.
- R9: At most one of `standby`, `carrier_en` and `line_pull` is 1 at any time. `standby` becomes 1 in the same cycle that `line_pull` falls.
- R10: The block's own pull-down, which returns as a low line sample during the pulse and shortly after it, does not wake the controller again.
- R11: The recorded fault is cleared whenever standby is entered, whether after an error pulse or after a watchdog timeout. The next clean frame ends with an acknowledge pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Synchronised line level, 1 = high |
| tick | input | 1 | Timing enable; all durations count these |
| fault_in | input | 1 | Fault indication, recorded while active |
| line_pull | output | 1 | Enables the line pull-down for the end-of-frame pulse |
| carrier_en | output | 1 | Enables the carrier driver |
| standby | output | 1 | 1 while the controller rests in standby |

## Verification
The line is looped back through a two-stage synchroniser, so the block sees its own pull-down exactly as it would on a real wire. Directed frames cover the following cases:
- Keying lows just below and above the enable window separate a correct low debounce from one that fires early or never.
- High glitches shorter than the release window, placed inside long keyed periods, separate proper high filtering from premature release and from a watchdog that fails to restart.
- Frames with and without a fault, and a frame that follows a timeout in which a fault occurred, show whether the pulse width tracks the recorded fault and whether the record is cleared.

Random frames then mix short and long lows with optional glitches. The expected carrier level and the acknowledge width for each frame come from bench functions.

// File: rtl/lfw_pkg.sv
package lfw_pkg;

   typedef enum logic [1:0] {
      PH_REST = 2'd0,
      PH_LIVE = 2'd1,
      PH_TAIL = 2'd2
   } phase_t;

   // bits needed to hold the value n
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lfw_run_timer.sv
// Counts ticks while the sampled level matches; any mismatch or clear zeroes it.
module lfw_run_timer #(
   parameter int unsigned LIMIT = 16,
   parameter int unsigned CW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          match,
   input  logic          tick,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] SAT = CW'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr || !match)
         count <= '0;
      else if (tick && (count != SAT))
         count <= count + 1'b1;
   end
endmodule

// File: rtl/lfw_end_pulse.sv
// End-of-frame pull-down; width picked at start from the fault record.
module lfw_end_pulse #(
   parameter int unsigned ACK_TICKS = 32,
   parameter int unsigned ERR_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic use_err,
   input  logic tick,
   output logic pull,
   output logic done
);
   import lfw_pkg::*;

   localparam int unsigned PW = cnt_bits(umax(ACK_TICKS, ERR_TICKS));
   localparam logic [PW-1:0] ACK_LAST = PW'(ACK_TICKS - 1);
   localparam logic [PW-1:0] ERR_LAST = PW'(ERR_TICKS - 1);

   logic          busy_q;
   logic          sel_err_q;
   logic [PW-1:0] cnt_q;
   logic [PW-1:0] last;

   assign last = sel_err_q ? ERR_LAST : ACK_LAST;
   assign done = busy_q && tick && (cnt_q == last);
   assign pull = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         sel_err_q <= 1'b0;
         cnt_q     <= '0;
      end else if (start) begin
         busy_q    <= 1'b1;
         sel_err_q <= use_err;
         cnt_q     <= '0;
      end else if (done) begin
         busy_q    <= 1'b0;
         cnt_q     <= '0;
      end else if (busy_q && tick) begin
         cnt_q     <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lfw_line_ctrl.sv
module lfw_line_ctrl #(
   parameter int unsigned DEB_LO_TICKS = 8,
   parameter int unsigned DEB_HI_TICKS = 8,
   parameter int unsigned STUCK_TICKS  = 2000,
   parameter int unsigned IDLE_TICKS   = 2000,
   parameter int unsigned ACK_TICKS    = 32,
   parameter int unsigned ERR_TICKS    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic tick,
   input  logic fault_in,
   output logic line_pull,
   output logic carrier_en,
   output logic standby
);
   import lfw_pkg::*;

   localparam int unsigned RUN_W = cnt_bits(umax(STUCK_TICKS, IDLE_TICKS));
   localparam logic [RUN_W-1:0] LIM_DEB_LO = RUN_W'(DEB_LO_TICKS);
   localparam logic [RUN_W-1:0] LIM_DEB_HI = RUN_W'(DEB_HI_TICKS);
   localparam logic [RUN_W-1:0] LIM_STUCK  = RUN_W'(STUCK_TICKS);
   localparam logic [RUN_W-1:0] LIM_IDLE   = RUN_W'(IDLE_TICKS);

   initial begin : p_param_check
      assert (DEB_LO_TICKS >= 1 && DEB_LO_TICKS < STUCK_TICKS)
         else $error("low debounce must be nonzero and below the stuck limit");
      assert (DEB_HI_TICKS >= 1 && DEB_HI_TICKS < IDLE_TICKS)
         else $error("high debounce must be nonzero and below the idle limit");
      assert (ACK_TICKS >= 1 && ERR_TICKS >= 1 && ACK_TICKS != ERR_TICKS)
         else $error("end pulse widths must be nonzero and distinct");
   end

   phase_t     phase_q, phase_d;
   logic       carrier_q, carrier_d;
   logic       fault_q;
   logic       armed_q;
   logic       live;
   logic       go_tail;
   logic       tail_done;
   logic       tail_pull;
   logic       enter_rest;
   logic [RUN_W-1:0] run_cnt [2];
   logic [RUN_W-1:0] lo_cnt;
   logic [RUN_W-1:0] hi_cnt;

   assign live = (phase_q == PH_LIVE);

   // index 0 times the low level, index 1 the high level
   for (genvar g = 0; g < 2; g++) begin : g_run
      localparam int unsigned LIM = (g == 0) ? STUCK_TICKS : IDLE_TICKS;
      lfw_run_timer #(
         .LIMIT (LIM),
         .CW    (RUN_W)
      ) u_run (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (!live),
         .match ((g == 0) ? !line_in : line_in),
         .tick  (tick),
         .count (run_cnt[g])
      );
   end

   assign lo_cnt = run_cnt[0];
   assign hi_cnt = run_cnt[1];

   always_comb begin
      phase_d   = phase_q;
      carrier_d = carrier_q;
      go_tail   = 1'b0;
      case (phase_q)
         PH_REST: begin
            carrier_d = 1'b0;
            if (armed_q && !line_in)
               phase_d = PH_LIVE;
         end
         PH_LIVE: begin
            if (lo_cnt >= LIM_STUCK) begin
               phase_d   = PH_REST;
               carrier_d = 1'b0;
            end else if (hi_cnt >= LIM_IDLE) begin
               phase_d   = PH_TAIL;
               carrier_d = 1'b0;
               go_tail   = 1'b1;
            end else if (!carrier_q && (lo_cnt >= LIM_DEB_LO)) begin
               carrier_d = 1'b1;
            end else if (carrier_q && (hi_cnt >= LIM_DEB_HI)) begin
               carrier_d = 1'b0;
            end
         end
         PH_TAIL: begin
            carrier_d = 1'b0;
            if (tail_done)
               phase_d = PH_REST;
         end
         default: begin
            phase_d   = PH_REST;
            carrier_d = 1'b0;
         end
      endcase
   end

   assign enter_rest = (phase_d == PH_REST) && (phase_q != PH_REST);

   lfw_end_pulse #(
      .ACK_TICKS (ACK_TICKS),
      .ERR_TICKS (ERR_TICKS)
   ) u_tail (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (go_tail),
      .use_err (fault_q | fault_in),
      .tick    (tick),
      .pull    (tail_pull),
      .done    (tail_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_REST;
         carrier_q <= 1'b0;
         fault_q   <= 1'b0;
         armed_q   <= 1'b0;
      end else begin
         phase_q   <= phase_d;
         carrier_q <= carrier_d;
         if (enter_rest)
            fault_q <= 1'b0;
         else if (live && fault_in)
            fault_q <= 1'b1;
         // wake needs a high sample seen while resting
         if ((phase_q == PH_REST) && (phase_d == PH_REST))
            armed_q <= armed_q | line_in;
         else
            armed_q <= 1'b0;
      end
   end

   assign line_pull  = tail_pull;
   assign carrier_en = carrier_q;
   assign standby    = (phase_q == PH_REST);

endmodule

// File: rtl/lfw_line_ctrl_chk.sv
module lfw_line_ctrl_chk #(
   parameter int unsigned STUCK_TICKS = 2000,
   parameter int unsigned ACK_TICKS   = 32,
   parameter int unsigned ERR_TICKS   = 16
) (
   input logic clk,
   input logic rst_n,
   input logic line_in,
   input logic tick,
   input logic line_pull,
   input logic carrier_en,
   input logic standby
);
   localparam int unsigned PMAX = (ACK_TICKS > ERR_TICKS) ? ACK_TICKS : ERR_TICKS;
   localparam int unsigned PW   = $clog2(PMAX + 2);
   localparam int unsigned LW   = $clog2(STUCK_TICKS + 3);
   localparam logic [LW-1:0] LSAT = LW'(STUCK_TICKS + 2);

   logic [PW-1:0] pcnt;
   logic [LW-1:0] lcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt <= '0;
      else if (line_pull)
         pcnt <= pcnt + PW'(tick);
      else
         pcnt <= '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lcnt <= '0;
      else if (!standby && !line_pull && !line_in) begin
         if (tick && (lcnt != LSAT))
            lcnt <= lcnt + 1'b1;
      end else
         lcnt <= '0;
   end

   AST_OUTPUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({standby, carrier_en, line_pull}));  // R9

   AST_PULSE_ENDS_IN_STBY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_pull) |-> standby);  // R9

   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_pull) |-> (pcnt == PW'(ACK_TICKS) || pcnt == PW'(ERR_TICKS)));  // R7

   AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(standby) |-> !$past(line_in));  // R2

   AST_CARRIER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carrier_en) |-> !$past(line_in));  // R3

   AST_STUCK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      lcnt <= LW'(STUCK_TICKS + 1));  // R5

endmodule

bind lfw_line_ctrl lfw_line_ctrl_chk #(
   .STUCK_TICKS (STUCK_TICKS),
   .ACK_TICKS   (ACK_TICKS),
   .ERR_TICKS   (ERR_TICKS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_in    (line_in),
   .tick       (tick),
   .line_pull  (line_pull),
   .carrier_en (carrier_en),
   .standby    (standby)
);

// File: tb/sim_lfw_line_ctrl.sv
module sim_lfw_line_ctrl;
   localparam int TDIV  = 4;
   localparam int DEB   = 6;
   localparam int STUCK = 80;
   localparam int IDLE  = 60;
   localparam int ACK   = 24;
   localparam int ERR   = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host = 1'b1;
   logic tick_r = 1'b0;
   logic fault_r = 1'b0;
   logic s1 = 1'b1;
   logic s2 = 1'b1;
   logic line_pull, carrier_en, standby;
   int   nchk = 0;
   int   nfail = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   // wired-AND line plus a two-stage synchroniser
   always @(posedge clk) begin
      s1 <= host & ~line_pull;
      s2 <= s1;
   end

   lfw_line_ctrl #(
      .DEB_LO_TICKS (DEB),
      .DEB_HI_TICKS (DEB),
      .STUCK_TICKS  (STUCK),
      .IDLE_TICKS   (IDLE),
      .ACK_TICKS    (ACK),
      .ERR_TICKS    (ERR)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_in    (s2),
      .tick       (tick_r),
      .fault_in   (fault_r),
      .line_pull  (line_pull),
      .carrier_en (carrier_en),
      .standby    (standby)
   );

   initial begin : tick_gen
      int ph;
      ph = 0;
      forever begin
         @(posedge clk);
         #1;
         ph = (ph + 1) % TDIV;
         tick_r = (ph == 0);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n * TDIV) @(negedge clk);
   endtask

   function automatic bit exp_on(input int low_ticks);
      return low_ticks >= DEB + 3;
   endfunction

   function automatic int exp_width(input bit had_fault);
      return had_fault ? ERR : ACK;
   endfunction

   task automatic frame_end(input int w, input string req);
      int waited;
      int cnt;
      bit bad;
      waited = 0;
      cnt = 0;
      bad = 1'b0;
      while (!line_pull && waited < (IDLE + 20) * TDIV) begin
         @(negedge clk);
         waited++;
      end
      chk(line_pull, {req, " pulse start"}, line_pull, 1);
      chk(waited >= (IDLE - 1) * TDIV, "R7 idle wait", waited, (IDLE - 1) * TDIV);
      while (line_pull) begin
         if (tick_r) cnt++;
         if (carrier_en || standby) bad = 1'b1;
         @(negedge clk);
      end
      chk(cnt == w, {req, " pulse width"}, cnt, w);
      chk(!bad, "R9 exclusive during pulse", bad, 0);
      chk(standby, "R9 standby at pulse end", standby, 1);
      repeat (8) @(negedge clk);
      chk(standby, "R10 no self wake", standby, 1);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual 0 expected 1");
         summary();
         $finish;
      end
   end

   initial begin : main
      int  l;
      bit  lg;
      void'($urandom(32'd2024));
      repeat (5) @(negedge clk);
      chk(standby && !carrier_en && !line_pull, "R1 in reset", standby, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(standby, "R1 after reset", standby, 1);
      chk(!carrier_en && !line_pull, "R1 outputs idle", carrier_en, 0);

      // wake and low debounce
      host = 1'b0;
      repeat (4) @(negedge clk);
      chk(!standby, "R2 wake", standby, 0);
      wt(2);
      chk(!carrier_en, "R3 early", carrier_en, 0);
      wt(DEB);
      chk(carrier_en, "R3 enabled", carrier_en, 1);

      // high glitch ignored, long high releases
      host = 1'b1;
      wt(2);
      chk(carrier_en, "R4 glitch", carrier_en, 1);
      host = 1'b0;
      wt(3);
      chk(carrier_en, "R4 after glitch", carrier_en, 1);
      host = 1'b1;
      wt(DEB + 3);
      chk(!carrier_en, "R4 released", carrier_en, 0);
      host = 1'b0;
      wt(DEB + 3);
      chk(carrier_en, "R3 re-enabled", carrier_en, 1);

      // watchdog refresh
      repeat (4) begin
         wt(50);
         host = 1'b1;
         wt(2);
         host = 1'b0;
      end
      wt(20);
      chk(carrier_en, "R6 carrier kept", carrier_en, 1);
      chk(!standby, "R6 still active", standby, 0);

      host = 1'b1;
      frame_end(exp_width(1'b0), "R7");

      // faulted frame
      host = 1'b0;
      wt(DEB + 3);
      fault_r = 1'b1;
      @(negedge clk);
      fault_r = 1'b0;
      wt(3);
      host = 1'b1;
      frame_end(exp_width(1'b1), "R8");

      host = 1'b0;
      wt(DEB + 3);
      host = 1'b1;
      frame_end(exp_width(1'b0), "R11 after error pulse");

      // stuck low with a fault pending
      host = 1'b0;
      wt(DEB + 3);
      fault_r = 1'b1;
      @(negedge clk);
      fault_r = 1'b0;
      wt(STUCK + 5);
      chk(standby, "R5 timeout standby", standby, 1);
      chk(!carrier_en, "R5 timeout carrier", carrier_en, 0);
      wt(20);
      chk(standby, "R5 stays in standby", standby, 1);
      host = 1'b1;
      wt(3);
      host = 1'b0;
      wt(DEB + 3);
      chk(carrier_en, "R2 wake after release", carrier_en, 1);
      host = 1'b1;
      frame_end(exp_width(1'b0), "R11 after timeout");

      // random frames
      for (int it = 0; it < 16; it++) begin
         lg = 1'($urandom_range(1, 0));
         l = lg ? int'($urandom_range(DEB + 20, DEB + 3)) : int'($urandom_range(DEB - 3, 1));
         host = 1'b0;
         wt(l);
         chk(carrier_en == exp_on(l), "R3 random low", carrier_en, exp_on(l));
         if (lg && ($urandom_range(1, 0) == 1)) begin
            host = 1'b1;
            wt(1 + int'($urandom_range(1, 0)));
            host = 1'b0;
            wt(4);
            chk(carrier_en, "R4 random glitch", carrier_en, 1);
         end
         host = 1'b1;
         frame_end(exp_width(1'b0), "R7 random");
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule